// File: doc/BRIEF.md
# Sampling Converter Serial Front End with Power Control

This block is the digital side of a multichannel sampling converter. A host reaches it through a four-wire serial slave port: a chip select (`cs_n`), a serial clock (`sclk`), serial data in (`din`) and serial data out (`dout`). Each frame is sixteen serial clocks long. During a frame the block returns one conversion result and can accept one register write. The analog section delivers the digitised sample, its sign and its channel number on a parallel input. The block asks that section to hold its input for the length of each frame.

The block keeps four configuration registers: control, sequence and two range registers. Two bits of the control register select the power mode. In full shutdown the block drops an enable to the analog section and returns a fixed invalid word. When it leaves shutdown, a power-up counter in the system clock domain keeps a ready flag low until the analog section has had time to settle. All serial inputs are synchronised into the system clock domain. `sclk` must therefore run well below the system clock: each serial clock level must last at least `SYNC_STAGES + 2` system clocks.

Top module: `adc_fe_ctrl`

## Requirements
- R1: After reset all four configuration registers are zero, the mode is normal (`pwr_en` = 1, `pwr_ready` = 1), `hold_req` is 0 and `dout` is 0.
- R2: A `cs_n` falling edge that is accepted starts a frame. `hold_req` stays high from that edge until `cs_n` rises. Channel, sign and sample value are captured at the start of the frame, so later changes on the sample inputs do not alter the returned word.
- R3: The returned word is {channel[2:0], sign, value[11:0]}. It is sent MSB first, one bit after each `sclk` falling edge, for 16 bits. `dout` is 0 outside a frame.
- R4: `din` is sampled on `sclk` rising edges. In the incoming word, bit 15 is the write flag, bits 14:13 select the target (00 control, 01 sequence, 10 range1, 11 range2), bits 12:1 are the data, and bit 0 is ignored. The write happens on the 15th rising edge only when bit 15 is 1. When bit 15 is 0, no register changes.
- R5: A frame ended by `cs_n` rising before the 15th `sclk` rising edge writes no register.
- R6: Control bits [1:0] are the power code, carried in word bits 2:1. Code 11 selects full shutdown, which drives `pwr_en` and `pwr_ready` low. Codes 00, 01 and 10 select normal mode. A change of mode takes effect on the 15th `sclk` rising edge of the frame that writes the control register.
- R7: Register contents are kept through shutdown. Writes to the sequence and range registers during shutdown are stored and do not change the mode. Only a control write with a code other than 11 ends shutdown.
- R8: A frame that starts in shutdown, or while power-up is still running, returns 16'hFFFF. This holds even when the frame's own write wakes the block.
- R9: On leaving shutdown, `pwr_en` rises and `pwr_ready` rises exactly `PWRUP_CYC` system clocks later.
- R10: A `cs_n` falling edge detected within `QUIET_CYC` system clocks of the last detected `cs_n` rising edge is ignored. No frame starts: `hold_req` stays low, `dout` stays 0 and no register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low, asynchronous |
| sclk | input | 1 | Serial clock, idles high, asynchronous |
| din | input | 1 | Serial data from host |
| dout | output | 1 | Serial data to host |
| hold_req | output | 1 | Sample-and-hold hold request for the current frame |
| smp_chan | input | CHAN_W | Channel number of the digitised sample |
| smp_sign | input | 1 | Sign of the digitised sample |
| smp_val | input | RES_W | Digitised sample value |
| pwr_en | output | 1 | Power enable to the analog section |
| pwr_ready | output | 1 | Analog section powered and settled |
| cfg_ctrl | output | CHAN_W+RES_W-3 | Control register |
| cfg_seq | output | CHAN_W+RES_W-3 | Sequence register |
| cfg_rng1 | output | CHAN_W+RES_W-3 | First range register |
| cfg_rng2 | output | CHAN_W+RES_W-3 | Second range register |

## Verification
A wrong bit counter or misaligned receive shifter shows up at once. The write lands in the wrong register or with shifted data, so the `cfg_*` ports disagree within a few system clocks of the 15th rising edge. A wrong power state shows up on `pwr_en` in the same frame that wrote it. It also shows up in the next frame's returned word, which is either a valid result where 16'hFFFF is expected or the reverse. A wrong power-up counter is caught by timing the interval from the rise of `pwr_en` to the rise of `pwr_ready`. Broken quiet-time tracking appears as a `hold_req` pulse or a register write during a frame that should have been ignored.

// File: rtl/adc_fe_pkg.sv
// Shared definitions for the converter serial front end.
// Assumes a two-bit register select and a two-bit power code.
package adc_fe_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'b00,
        SEL_SEQ  = 2'b01,
        SEL_RNG1 = 2'b10,
        SEL_RNG2 = 2'b11
    } reg_sel_e;

    localparam int unsigned NUM_REGS = 4;

    localparam logic [1:0] PM_SHUTDOWN = 2'b11;

    // True when a power code selects full shutdown; every other code is normal.
    function automatic logic pm_is_shutdown(input logic [1:0] code);
        return code == PM_SHUTDOWN;
    endfunction

endpackage

// File: rtl/adc_fe_sync.sv
// Multi-stage synchroniser for a group of asynchronous inputs.
// It also provides a one-cycle-delayed copy of the synchronised value for edge detection.
// Assumes STAGES >= 2 and inputs that change slower than the system clock.
module adc_fe_sync #(
    parameter int unsigned N       = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_async,
    output logic [N-1:0] q,
    output logic [N-1:0] q_prev
);

    logic [STAGES:0][N-1:0] pipe;

    // Shift asynchronous inputs through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= {(STAGES+1){RST_VAL}};
        else        pipe <= {pipe[STAGES-1:0], d_async};
    end

    assign q      = pipe[STAGES-1];
    assign q_prev = pipe[STAGES];

endmodule

// File: rtl/adc_fe_frame.sv
// Serial frame engine. It accepts or ignores chip-select falls (quiet time),
// captures the sample, shifts the result out on sclk falls and shifts din in
// on sclk rises. It issues a one-cycle write strobe at the commit rise.
// Assumes edge pulses come from the synchroniser and are one clock wide.
module adc_fe_frame #(
    parameter int unsigned CHAN_W    = 3,
    parameter int unsigned RES_W     = 12,
    parameter int unsigned QUIET_CYC = 12,
    localparam int unsigned FRAME_LEN = CHAN_W + 1 + RES_W,
    localparam int unsigned REG_W     = FRAME_LEN - 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              din_s,
    input  logic [CHAN_W-1:0] smp_chan,
    input  logic              smp_sign,
    input  logic [RES_W-1:0]  smp_val,
    input  logic              inv_req,
    output logic              dout,
    output logic              active,
    output logic              wr_stb,
    output logic [1:0]        wr_sel,
    output logic [REG_W-1:0]  wr_data
);

    localparam int unsigned COMMIT = FRAME_LEN - 1;
    localparam int unsigned CNT_W  = $clog2(FRAME_LEN + 1);
    localparam int unsigned QW     = $clog2(QUIET_CYC + 1);

    logic [FRAME_LEN-1:0] tx_sh;
    logic [FRAME_LEN-3:0] rx_sh;
    logic [CNT_W-1:0]     rise_cnt;
    logic [QW-1:0]        quiet_cnt;
    logic [FRAME_LEN-2:0] rx_word;
    logic                 start_ok;

    assign start_ok = cs_fall && !active && (quiet_cnt == '0);
    assign rx_word  = {rx_sh, din_s};

    // Frame state: start, end, transmit shift and quiet-time count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            dout      <= 1'b0;
            tx_sh     <= '0;
            quiet_cnt <= '0;
        end else if (start_ok) begin
            active <= 1'b1;
            dout   <= 1'b0;
            tx_sh  <= inv_req ? '1 : {smp_chan, smp_sign, smp_val};
        end else if (cs_rise) begin
            active    <= 1'b0;
            dout      <= 1'b0;
            quiet_cnt <= QW'(QUIET_CYC);
        end else begin
            if (quiet_cnt != '0) quiet_cnt <= quiet_cnt - 1'b1;
            if (active && sclk_fall) begin
                dout  <= tx_sh[FRAME_LEN-1];
                tx_sh <= {tx_sh[FRAME_LEN-2:0], 1'b0};
            end
        end
    end

    // Receive shift and rising-edge count within the frame.
    always_ff @(posedge clk) begin
        if (!rst_n || start_ok) begin
            rx_sh    <= '0;
            rise_cnt <= '0;
        end else if (active && sclk_rise) begin
            rx_sh <= rx_word[FRAME_LEN-3:0];
            if (rise_cnt != CNT_W'(FRAME_LEN)) rise_cnt <= rise_cnt + 1'b1;
        end
    end

    // Write strobe on the commit rise when the write flag is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb  <= 1'b0;
            wr_sel  <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= active && sclk_rise && !cs_rise
                      && (rise_cnt == CNT_W'(COMMIT - 1))
                      && rx_word[FRAME_LEN-2];
            if (active && sclk_rise) begin
                wr_sel  <= rx_word[FRAME_LEN-3 -: 2];
                wr_data <= rx_word[REG_W-1:0];
            end
        end
    end

endmodule

// File: rtl/adc_fe_regs.sv
// Four configuration registers written by the frame engine's strobe.
// It also flags control writes for the power controller.
// Assumes at most one write strobe per frame.
module adc_fe_regs
    import adc_fe_pkg::*;
#(
    parameter int unsigned REG_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [1:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] reg_q [NUM_REGS],
    output logic             ctrl_wr
);

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            // Hold one configuration register; load on a matching strobe.
            always_ff @(posedge clk) begin
                if (!rst_n)                                reg_q[g] <= '0;
                else if (wr_stb && (wr_sel == 2'(g)))      reg_q[g] <= wr_data;
            end
        end
    endgenerate

    assign ctrl_wr = wr_stb && (reg_sel_e'(wr_sel) == SEL_CTRL);

endmodule

// File: rtl/adc_fe_power.sv
// Power-state controller: normal or full shutdown, plus a power-up timer.
// Ready stays low from the start of power-up until PWRUP_CYC clocks pass.
// Assumes the power code arrives with a one-cycle control-write pulse.
module adc_fe_power
    import adc_fe_pkg::*;
#(
    parameter int unsigned PWRUP_CYC = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pm_wr,
    input  logic [1:0] pm_code,
    output logic       pwr_en,
    output logic       pwr_ready
);

    localparam int unsigned PW = $clog2(PWRUP_CYC + 1);

    logic          shut;
    logic [PW-1:0] pu_cnt;

    // Track power state and count down the power-up delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shut   <= 1'b0;
            pu_cnt <= '0;
        end else if (pm_wr) begin
            shut <= pm_is_shutdown(pm_code);
            if (pm_is_shutdown(pm_code))  pu_cnt <= '0;
            else if (shut)                pu_cnt <= PW'(PWRUP_CYC);
            else if (pu_cnt != '0)        pu_cnt <= pu_cnt - 1'b1;
        end else if (pu_cnt != '0) begin
            pu_cnt <= pu_cnt - 1'b1;
        end
    end

    assign pwr_en    = !shut;
    assign pwr_ready = !shut && (pu_cnt == '0);

endmodule

// File: rtl/adc_fe_ctrl.sv
// Top of the converter serial front end. It synchronises the serial pins,
// runs the frame engine, holds the configuration registers and controls power.
// Assumes each sclk level lasts at least SYNC_STAGES + 2 system clocks.
module adc_fe_ctrl
    import adc_fe_pkg::*;
#(
    parameter int unsigned CHAN_W      = 3,
    parameter int unsigned RES_W       = 12,
    parameter int unsigned PWRUP_CYC   = 60,
    parameter int unsigned QUIET_CYC   = 12,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_n,
    input  logic                    sclk,
    input  logic                    din,
    output logic                    dout,
    output logic                    hold_req,
    input  logic [CHAN_W-1:0]       smp_chan,
    input  logic                    smp_sign,
    input  logic [RES_W-1:0]        smp_val,
    output logic                    pwr_en,
    output logic                    pwr_ready,
    output logic [CHAN_W+RES_W-4:0] cfg_ctrl,
    output logic [CHAN_W+RES_W-4:0] cfg_seq,
    output logic [CHAN_W+RES_W-4:0] cfg_rng1,
    output logic [CHAN_W+RES_W-4:0] cfg_rng2
);

    localparam int unsigned REG_W = CHAN_W + RES_W - 3;

    logic [2:0]       pin_q, pin_p;
    logic             cs_fall, cs_rise, sclk_rise, sclk_fall;
    logic             wr_stb, ctrl_wr;
    logic [1:0]       wr_sel;
    logic [REG_W-1:0] wr_data;
    logic [REG_W-1:0] reg_q [NUM_REGS];

    adc_fe_sync #(
        .N       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b011)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({din, sclk, cs_n}),
        .q       (pin_q),
        .q_prev  (pin_p)
    );

    assign cs_fall   = !pin_q[0] &&  pin_p[0];
    assign cs_rise   =  pin_q[0] && !pin_p[0];
    assign sclk_fall = !pin_q[1] &&  pin_p[1];
    assign sclk_rise =  pin_q[1] && !pin_p[1];

    adc_fe_frame #(
        .CHAN_W    (CHAN_W),
        .RES_W     (RES_W),
        .QUIET_CYC (QUIET_CYC)
    ) i_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .din_s     (pin_q[2]),
        .smp_chan  (smp_chan),
        .smp_sign  (smp_sign),
        .smp_val   (smp_val),
        .inv_req   (!pwr_ready),
        .dout      (dout),
        .active    (hold_req),
        .wr_stb    (wr_stb),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data)
    );

    adc_fe_regs #(
        .REG_W (REG_W)
    ) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .reg_q   (reg_q),
        .ctrl_wr (ctrl_wr)
    );

    adc_fe_power #(
        .PWRUP_CYC (PWRUP_CYC)
    ) i_power (
        .clk       (clk),
        .rst_n     (rst_n),
        .pm_wr     (ctrl_wr),
        .pm_code   (wr_data[1:0]),
        .pwr_en    (pwr_en),
        .pwr_ready (pwr_ready)
    );

    assign cfg_ctrl = reg_q[SEL_CTRL];
    assign cfg_seq  = reg_q[SEL_SEQ];
    assign cfg_rng1 = reg_q[SEL_RNG1];
    assign cfg_rng2 = reg_q[SEL_RNG2];

endmodule

// File: rtl/adc_fe_ctrl_chk.sv
// Property checker for the serial front end, bound to the top module.
module adc_fe_ctrl_chk #(
    parameter int unsigned REG_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             hold_req,
    input logic             dout,
    input logic             pwr_en,
    input logic             pwr_ready,
    input logic [REG_W-1:0] cfg_ctrl
);

    // R6
    ready_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |-> !pwr_ready);

    // R9
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_ready) |-> $past(pwr_en));

    // R2
    hold_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_req) |-> !cs_n);

    // R3
    dout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_req |-> !dout);

    // R4
    ctrl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ctrl != $past(cfg_ctrl)) |-> $past(hold_req));

    // R7
    pwr_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pwr_en) |-> $past(hold_req));

endmodule

bind adc_fe_ctrl adc_fe_ctrl_chk #(
    .REG_W (CHAN_W + RES_W - 3)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .hold_req  (hold_req),
    .dout      (dout),
    .pwr_en    (pwr_en),
    .pwr_ready (pwr_ready),
    .cfg_ctrl  (cfg_ctrl)
);

// File: tb/test_adc_fe_ctrl.sv
`timescale 1ns/1ps
module test_adc_fe_ctrl;

    localparam int PWRUP = 60;
    localparam int QUIET = 12;
    localparam int HALF  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, sclk = 1'b1, din = 1'b0;
    logic        dout, hold_req, pwr_en, pwr_ready;
    logic [2:0]  smp_chan = '0;
    logic        smp_sign = 1'b0;
    logic [11:0] smp_val = '0;
    logic [11:0] cfg_ctrl, cfg_seq, cfg_rng1, cfg_rng2;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    logic [11:0] m_reg [4];
    bit          m_shut = 0, m_warm = 1;
    int          pu_meas = -1;

    always #2 clk = ~clk;

    adc_fe_ctrl #(.PWRUP_CYC(PWRUP), .QUIET_CYC(QUIET)) i_adc_fe_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .dout(dout), .hold_req(hold_req), .smp_chan(smp_chan),
        .smp_sign(smp_sign), .smp_val(smp_val), .pwr_en(pwr_en),
        .pwr_ready(pwr_ready), .cfg_ctrl(cfg_ctrl), .cfg_seq(cfg_seq),
        .cfg_rng1(cfg_rng1), .cfg_rng2(cfg_rng2));

    // Measure clocks from pwr_en rising to pwr_ready rising (R9).
    logic pe_prev = 1'b1, rd_prev = 1'b1;
    int   pu_t = 0;
    always @(posedge clk) begin
        #1;
        if (pwr_en && !pe_prev) pu_t = 0;
        else                    pu_t = pu_t + 1;
        if (pwr_ready && !rd_prev) pu_meas = pu_t;
        pe_prev = pwr_en;
        rd_prev = pwr_ready;
    end

    function automatic logic [15:0] mk_word(input bit wr, input logic [1:0] sel,
                                            input logic [11:0] data);
        return {wr, sel, data, 1'b0};
    endfunction

    function automatic logic [15:0] exp_word(input bit inv, input logic [2:0] ch,
                                             input logic sg, input logic [11:0] v);
        return inv ? 16'hFFFF : {ch, sg, v};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Run one frame of nbits clocks; gap clocks of idle follow cs_n rising.
    task automatic frame(input logic [15:0] tx, input int nbits, input int gap,
                         output logic [15:0] rx, output logic [15:0] pe, output bit hs);
        rx = '0; pe = '0; hs = 0;
        cs_n = 1'b0;
        tick(HALF);
        hs = hold_req;
        smp_chan = 3'($urandom); smp_sign = 1'($urandom); smp_val = 12'($urandom);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0; din = tx[15-i];
            tick(HALF);
            rx[15-i] = dout;
            hs = hs | hold_req;
            sclk = 1'b1;
            tick(HALF);
            pe[15-i] = pwr_en;
        end
        cs_n = 1'b1;
        tick(gap);
    endtask

    // Bench model update after a completed frame.
    task automatic model_write(input logic [15:0] tx);
        if (tx[15]) begin
            m_reg[tx[14:13]] = tx[12:1];
            if (tx[14:13] == 2'b00) begin
                if (m_shut && tx[2:1] != 2'b11) m_warm = 0;
                m_shut = (tx[2:1] == 2'b11);
            end
        end
    endtask

    task automatic check_regs(input string req);
        check({req, " ctrl"}, cfg_ctrl, m_reg[0]);
        check({req, " seq"},  cfg_seq,  m_reg[1]);
        check({req, " rng1"}, cfg_rng1, m_reg[2]);
        check({req, " rng2"}, cfg_rng2, m_reg[3]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] rx, pe, tx, ex;
        logic [2:0]  ch; logic sg; logic [11:0] v;
        bit hs, inv;
        void'($urandom(32'd2417));
        for (int k = 0; k < 4; k++) m_reg[k] = '0;
        tick(5);
        rst_n = 1'b1;
        tick(3);

        // R1 reset state
        check_regs("R1");
        check("R1 pwr_en", pwr_en, 1);
        check("R1 ready", pwr_ready, 1);
        check("R1 dout", dout, 0);
        check("R1 hold", hold_req, 0);

        // R2/R3 read with capture at start (inputs scrambled inside frame)
        smp_chan = 3'd5; smp_sign = 1'b1; smp_val = 12'hABC;
        frame(16'h0000, 16, QUIET + 4, rx, pe, hs);
        check("R3 word", rx, 16'hBABC);
        check("R2 hold seen", hs, 1);
        check("R2 hold after", hold_req, 0);

        // R4 write to sequence
        tx = mk_word(1, 2'b01, 12'h5A3);
        frame(tx, 16, QUIET + 4, rx, pe, hs); model_write(tx);
        check("R4 seq write", cfg_seq, 12'h5A3);

        // R4 write flag clear: nothing stored
        tx = mk_word(0, 2'b10, 12'hFFF);
        frame(tx, 16, QUIET + 4, rx, pe, hs);
        check_regs("R4 no-write");

        // R5 abort after 14 rising edges
        tx = mk_word(1, 2'b10, 12'h777);
        frame(tx, 14, QUIET + 4, rx, pe, hs);
        check("R5 aborted rng1", cfg_rng1, 12'h000);

        // R6 codes 01 and 10 stay normal
        tx = mk_word(1, 2'b00, 12'h031);
        frame(tx, 16, QUIET + 4, rx, pe, hs); model_write(tx);
        check("R6 code01 pwr", pwr_en, 1);
        tx = mk_word(1, 2'b00, 12'h032);
        frame(tx, 16, QUIET + 4, rx, pe, hs); model_write(tx);
        check("R6 code10 pwr", pwr_en, 1);
        check("R6 code10 ready", pwr_ready, 1);

        // R6 enter shutdown on the 15th rise
        tx = mk_word(1, 2'b00, 12'h0A7);
        frame(tx, 16, QUIET + 4, rx, pe, hs); model_write(tx);
        check("R6 pwr after 14th rise", pe[2], 1);
        check("R6 pwr after 15th rise", pe[1], 0);
        check("R6 ready in shutdown", pwr_ready, 0);

        // R7/R8 write range2 while shut
        tx = mk_word(1, 2'b11, 12'h3C5);
        frame(tx, 16, QUIET + 4, rx, pe, hs); model_write(tx);
        check("R8 invalid in shutdown", rx, 16'hFFFF);
        check("R7 still shut", pwr_en, 0);
        check_regs("R7 retained");

        // R8/R9 wake frame returns invalid; power-up timing
        tx = mk_word(1, 2'b00, 12'h0A4);
        frame(tx, 16, QUIET + 4, rx, pe, hs); model_write(tx);
        check("R8 wake frame invalid", rx, 16'hFFFF);
        check("R6 wake after 15th rise", pe[1], 1);
        check("R6 wake before 15th rise", pe[2], 0);
        check("R9 not ready yet", pwr_ready, 0);
        frame(16'h0000, 16, PWRUP + 20, rx, pe, hs);
        check("R8 frame during power-up", rx, 16'hFFFF);
        check("R9 ready later", pwr_ready, 1);
        check("R9 power-up clocks", pu_meas, PWRUP);
        m_warm = 1;

        // R10 frame inside quiet time is ignored
        frame(16'h0000, 16, 2, rx, pe, hs);
        tx = mk_word(1, 2'b01, 12'h123);
        frame(tx, 16, QUIET + 4, rx, pe, hs);
        check("R10 hold low", hs, 0);
        check("R10 dout zero", rx, 16'h0000);
        check("R10 seq kept", cfg_seq, m_reg[1]);

        // Random frames against the model
        for (int n = 0; n < 60; n++) begin
            logic [1:0] sel;
            logic [11:0] data;
            sel  = 2'($urandom);
            data = 12'($urandom);
            if (sel == 2'b00 && ($urandom % 3) != 0) data[1:0] = 2'b00;
            tx = mk_word(1'($urandom % 4 != 0), sel, data);
            ch = 3'($urandom); sg = 1'($urandom); v = 12'($urandom);
            smp_chan = ch; smp_sign = sg; smp_val = v;
            inv = m_shut || !m_warm;
            ex  = exp_word(inv, ch, sg, v);
            frame(tx, 16, QUIET + 4, rx, pe, hs);
            model_write(tx);
            check("R3/R8 random word", rx, ex);
            check_regs("R4 random regs");
            check("R6 random pwr_en", pwr_en, !m_shut);
            if (!m_warm) begin
                tick(PWRUP + 10);
                m_warm = 1;
                check("R9 random ready", pwr_ready, 1);
            end
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule